// File: doc/BRIEF.md
# Crystal Activity Watchdog and Clock Source Selector

This block decides where the CPU clock comes from. It runs on a free-running reference clock taken from the on-chip PLL. It watches an external crystal input for rising edges. The crystal signal passes through a two-stage synchronizer into the reference domain, and a rising-edge detector follows it. A counter measures how long it has been since the last detected edge.

Monitoring happens only while the PLL is bypassed and the watchdog is enabled. In that state, if the crystal stays silent for the timeout, the block makes two changes: it latches a fault and moves the clock source to the PLL base frequency. The timeout defaults to 5000 reference cycles, which is 1 ms at a base rate of about 5 MHz. Both the fault and the fallback stay in force until reset, even if the crystal starts toggling again.

When the watchdog is disabled while the PLL is bypassed, the crystal always drives the CPU clock, and the block asks for the PLL to be powered down. This request is withheld once a fault has latched, because from then on the CPU runs from the PLL.

Top module: `osc_activity_wdog`

## Requirements
- R1: While `rst_n` is low and right after it rises, `xtal_fault` is 0.
- R2: `xtal_in` reaches the edge detector through two `ref_clk` flops. A high pulse one reference cycle wide still counts as a rising edge.
- R3: Every detected rising edge restarts the inactivity count. Successive synchronized rising edges that are at most `TIMEOUT_CYCLES` reference cycles apart never set the fault.
- R4: Monitoring requires `pll_bypass`=1 and `wdog_disable`=0. In that state, a gap of `TIMEOUT_CYCLES`+1 or more cycles between synchronized rising edges sets `xtal_fault`. The same applies to the time from reset, or from the start of monitoring, to the first edge.
- R5: Once set, `xtal_fault` stays 1 until reset. Returning crystal activity and configuration changes do not clear it.
- R6: When monitoring is off (`pll_bypass`=0 or `wdog_disable`=1), the inactivity count is held at zero. No crystal pattern can set the fault, and re-enabling monitoring starts a fresh timeout.
- R7: `clk_src` encodes the source as 0 for the crystal and 1 for the PLL. It is 1 whenever `pll_bypass`=0.
- R8: With `pll_bypass`=1 and no fault, `clk_src` is 0. This holds whether the watchdog is enabled or disabled.
- R9: With `pll_bypass`=1 and `xtal_fault`=1, `clk_src` is 1, which is the fallback to the PLL base frequency.
- R10: `pll_pdn_req` is 1 exactly when `pll_bypass`=1, `wdog_disable`=1 and `xtal_fault`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Free-running reference clock from the PLL base oscillator |
| rst_n | input | 1 | Asynchronous active-low reset |
| xtal_in | input | 1 | Crystal clock input being monitored (asynchronous) |
| pll_bypass | input | 1 | 1: PLL bypassed, crystal is the normal CPU clock |
| wdog_disable | input | 1 | 1: activity watchdog disabled |
| clk_src | output | 1 | CPU clock source: 0 crystal, 1 PLL |
| pll_pdn_req | output | 1 | Request to power down the PLL |
| xtal_fault | output | 1 | Sticky crystal inactivity fault |

## Verification
The bench builds the block with `TIMEOUT_CYCLES` = 20 instead of 5000, so that timeouts and sticky behaviour fit within a few hundred cycles. At that value, crystal periods of exactly 20 and 21 reference cycles can both be driven. This places the fault threshold between two adjacent edge spacings. The short value also lets the bench hold the crystal silent for several timeouts while monitoring is off. It can then re-enable monitoring and watch the count restart, all inside one run.

// File: rtl/osc_wdog_pkg.sv
package osc_wdog_pkg;
  localparam int SYNC_STAGES = 2;

  typedef enum logic {
    SRC_XTAL = 1'b0,
    SRC_PLL  = 1'b1
  } clk_src_e;
endpackage

// File: rtl/owd_sync.sv
module owd_sync #(
  parameter int STAGES = 2
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic async_in,
  output logic sync_out
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge ref_clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge ref_clk or negedge rst_n) begin
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
        end
      end
    end
  endgenerate

  assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/owd_idle_timer.sv
module owd_idle_timer #(
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic xtal_sync,
  input  logic mon_en,
  output logic rise,
  output logic expire
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);
  localparam logic [CW-1:0] LAST = CW'(TIMEOUT_CYCLES - 1);

  logic          prev_q;
  logic [CW-1:0] idle_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b0;
    else        prev_q <= xtal_sync;
  end

  assign rise = xtal_sync & ~prev_q;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)                idle_q <= '0;
    else if (!mon_en || rise)  idle_q <= '0;
    else if (idle_q != LAST)   idle_q <= idle_q + 1'b1;
  end

  assign expire = mon_en & ~rise & (idle_q == LAST);

  assert_count_restart_R3: assert property (@(posedge ref_clk) disable iff (!rst_n)
    rise |=> (idle_q == '0));
  assert_count_held_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_en |=> (idle_q == '0));
  assert_count_bound_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    idle_q <= LAST);
endmodule

// File: rtl/owd_src_ctl.sv
module owd_src_ctl
  import osc_wdog_pkg::*;
(
  input  logic     ref_clk,
  input  logic     rst_n,
  input  logic     expire,
  input  logic     mon_en,
  input  logic     pll_bypass,
  input  logic     wdog_disable,
  output clk_src_e src,
  output logic     pdn_req,
  output logic     fault
);
  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n)      fault <= 1'b0;
    else if (expire) fault <= 1'b1;
  end

  always_comb begin
    if (!pll_bypass || fault) src = SRC_PLL;
    else                      src = SRC_XTAL;
  end

  assign pdn_req = pll_bypass & wdog_disable & ~fault;

  assert_fault_sticky_R5: assert property (@(posedge ref_clk) disable iff (!rst_n)
    fault |=> fault);
  assert_fault_needs_expiry_R4: assert property (@(posedge ref_clk) disable iff (!rst_n)
    $rose(fault) |-> $past(expire));
  assert_no_fault_unmonitored_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (!mon_en && !fault) |=> !fault);
endmodule

// File: rtl/osc_activity_wdog.sv
module osc_activity_wdog
  import osc_wdog_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 5000
) (
  input  logic ref_clk,
  input  logic rst_n,
  input  logic xtal_in,
  input  logic pll_bypass,
  input  logic wdog_disable,
  output logic clk_src,
  output logic pll_pdn_req,
  output logic xtal_fault
);
  logic     xtal_sync;
  logic     rise;
  logic     expire;
  logic     mon_en;
  clk_src_e src;

  assign mon_en = pll_bypass & ~wdog_disable;

  owd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .ref_clk (ref_clk),
    .rst_n   (rst_n),
    .async_in(xtal_in),
    .sync_out(xtal_sync)
  );

  owd_idle_timer #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
    .ref_clk  (ref_clk),
    .rst_n    (rst_n),
    .xtal_sync(xtal_sync),
    .mon_en   (mon_en),
    .rise     (rise),
    .expire   (expire)
  );

  owd_src_ctl u_ctl (
    .ref_clk     (ref_clk),
    .rst_n       (rst_n),
    .expire      (expire),
    .mon_en      (mon_en),
    .pll_bypass  (pll_bypass),
    .wdog_disable(wdog_disable),
    .src         (src),
    .pdn_req     (pll_pdn_req),
    .fault       (xtal_fault)
  );

  assign clk_src = src;

  assert_pdn_keeps_xtal_R10: assert property (@(posedge ref_clk) disable iff (!rst_n)
    pll_pdn_req |-> !clk_src);
  assert_fault_selects_pll_R9: assert property (@(posedge ref_clk) disable iff (!rst_n)
    xtal_fault |-> clk_src);
  assert_no_expiry_idle_R6: assert property (@(posedge ref_clk) disable iff (!rst_n)
    !mon_en |-> !expire);
endmodule

// File: tb/tb_osc_activity_wdog.sv
module tb_osc_activity_wdog;
  localparam int CLK_PERIOD = 10;
  localparam int TMO = 20;

  logic ref_clk = 1'b0;
  logic rst_n = 1'b0;
  logic xtal_in = 1'b0;
  logic pll_bypass = 1'b1;
  logic wdog_disable = 1'b0;
  logic clk_src, pll_pdn_req, xtal_fault;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  osc_activity_wdog #(.TIMEOUT_CYCLES(TMO)) dut (
    .ref_clk(ref_clk), .rst_n(rst_n), .xtal_in(xtal_in),
    .pll_bypass(pll_bypass), .wdog_disable(wdog_disable),
    .clk_src(clk_src), .pll_pdn_req(pll_pdn_req), .xtal_fault(xtal_fault)
  );

  always #(CLK_PERIOD/2) ref_clk = ~ref_clk;

  // behavioural reference: history of sampled crystal values, idle time, fault
  bit hist[$] = '{0, 0, 0};
  int idle = 0;
  bit m_fault = 0;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge ref_clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      idle = 0;
      m_fault = 0;
    end else begin
      bit edge_seen;
      bit monitoring;
      edge_seen = hist[1] && !hist[2];
      monitoring = pll_bypass && !wdog_disable;
      if (!monitoring || edge_seen) idle = 0;
      else begin
        idle++;
        if (idle > TMO - 1) m_fault = 1;
      end
      void'(hist.pop_back());
      hist.push_front(xtal_in);
    end
    #(CLK_PERIOD/4);
    if (!done) begin
      check(xtal_fault == m_fault, "R4 fault (R2 sync latency)", xtal_fault, m_fault);
      check(clk_src == (!pll_bypass || m_fault), "R7/R8/R9 clk_src", clk_src,
            int'(!pll_bypass || m_fault));
      check(pll_pdn_req == (pll_bypass && wdog_disable && !m_fault), "R10 pll_pdn_req",
            pll_pdn_req, int'(pll_bypass && wdog_disable && !m_fault));
    end
  end

  task automatic cycles(input int n);
    repeat (n) @(negedge ref_clk);
  endtask

  // crystal pulses one cycle high with the given period
  task automatic toggle(input int period, input int count);
    for (int i = 0; i < count; i++) begin
      @(negedge ref_clk) xtal_in = 1'b1;
      @(negedge ref_clk) xtal_in = 1'b0;
      cycles(period - 2);
    end
  endtask

  task automatic do_reset;
    @(negedge ref_clk) rst_n = 1'b0;
    xtal_in = 1'b0;
    cycles(3);
    @(negedge ref_clk) rst_n = 1'b1;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual hung expected finish");
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    cycles(3);
    check(xtal_fault == 0, "R1 fault in reset", xtal_fault, 0);
    @(negedge ref_clk) rst_n = 1'b1;
    #1 check(xtal_fault == 0, "R1 fault after reset", xtal_fault, 0);
    check(clk_src == 0, "R8 crystal selected", clk_src, 0);

    // R3: period exactly TMO never faults, 1-cycle pulses pass the R2 sync
    toggle(TMO, 8);
    check(xtal_fault == 0, "R3 period TMO no fault", xtal_fault, 0);

    // R4: period TMO+1 faults
    toggle(TMO + 1, 3);
    #1 check(xtal_fault == 1, "R4 period TMO+1 faults", xtal_fault, 1);
    check(clk_src == 1, "R9 fallback to PLL", clk_src, 1);

    // R5: activity returns, config changes
    toggle(5, 10);
    @(negedge ref_clk) wdog_disable = 1'b1;
    cycles(4);
    @(negedge ref_clk) pll_bypass = 1'b0;
    cycles(4);
    #1 check(xtal_fault == 1, "R5 fault sticky", xtal_fault, 1);
    check(pll_pdn_req == 0, "R10 no pdn after fault", pll_pdn_req, 0);

    // R6 / R8 / R10: disabled and bypassed, silent crystal
    pll_bypass = 1'b1;
    do_reset();
    cycles(3 * TMO);
    #1 check(xtal_fault == 0, "R6 disabled no fault", xtal_fault, 0);
    check(clk_src == 0, "R8 crystal when disabled", clk_src, 0);
    check(pll_pdn_req == 1, "R10 pdn request", pll_pdn_req, 1);

    // R6 / R7: PLL not bypassed, silent crystal
    @(negedge ref_clk) begin pll_bypass = 1'b0; wdog_disable = 1'b0; end
    cycles(3 * TMO);
    #1 check(xtal_fault == 0, "R6 not bypassed no fault", xtal_fault, 0);
    check(clk_src == 1, "R7 PLL when not bypassed", clk_src, 1);

    // R6: re-enable starts a fresh timeout
    @(negedge ref_clk) pll_bypass = 1'b1;
    cycles(TMO - 2);
    #1 check(xtal_fault == 0, "R6 fresh timeout", xtal_fault, 0);
    cycles(4);
    #1 check(xtal_fault == 1, "R4 timeout from enable", xtal_fault, 1);

    cycles(3);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule